// File: doc/BRIEF.md
# Active-Core-Count Boost Controller

This controller sits beside a small multi-core cluster and decides how hard the cluster may be pushed, based on how many of its cores are awake. On each accepted sample strobe it takes a snapshot of the per-core awake vector and counts the set bits. From that count it chooses a frequency code and a power-density gain target. The gain target passes through an eight-sample moving average before it is published. The published per-core power budget is the base budget scaled by that smoothed gain. Because of the average, the budget ramps over several samples when cores go to sleep or wake, and does not jump.

Two policies are selectable per sample. In the threshold policy, the frequency code is raised only while the awake count is small, and the gain stays at unity. In the graded policy, any non-zero awake count raises the frequency code. The gain then grows with the number of sleeping cores, following a fixed table. A sleeping core's share is not handed over one-for-one: the table alone sets the gain. The controller runs as a three-state machine. `ST_WAIT` moves to `ST_ACCUM` when a strobe is accepted ("accept"). `ST_ACCUM` always moves to `ST_PUBLISH` ("shift", which pushes the new target into the average history). `ST_PUBLISH` always returns to `ST_WAIT` ("publish", which loads the outputs). `ST_WAIT` holds while no strobe arrives ("idle").

Top module: `acb_boost_ctrl`

## Requirements
- R1: While reset is asserted, and until the first publish, `freq_code` equals `FREQ_BASE` (default 1), `mult_smooth` equals 64 (unity in unsigned Q2.6) and `core_budget` equals 0.
- R2: In the threshold policy (`graded_mode` = 0 at accept), the published `freq_code` is `FREQ_BOOST` (default 2) when the captured awake count is 1 to `BOOST_THRESH` (default 3), and `FREQ_BASE` otherwise, including a count of zero.
- R3: In the graded policy (`graded_mode` = 1 at accept), the published `freq_code` is `FREQ_BOOST` for any non-zero awake count and `FREQ_BASE` for a count of zero.
- R4: The gain target, in Q2.6, is 64 in the threshold policy. In the graded policy, with four cores, it is 64 for 4 awake, 77 for 3, 102 for 2, 128 for 1, and 64 for 0 awake.
- R5: `mult_smooth` is the floor of the sum of the last eight gain targets divided by eight. After reset, the history holds eight values of 64.
- R6: A strobe seen high at a rising edge while the controller is in `ST_WAIT` is accepted. The outputs take their new values at the second rising edge after it and hold at all other edges.
- R7: A strobe seen high at either of the two edges that follow an accepted strobe is ignored. It neither changes the history nor delays the next publish.
- R8: `core_budget` is bits [BUDGET_W-1:0] of floor(`base_budget` × `mult_smooth` / 64). `base_budget` is sampled at the publishing edge, so with a gain of 64 the budget equals the base.
- R9: Successive published `mult_smooth` values differ by at most 8, one eighth of the table span.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_stb | input | 1 | Sample request strobe |
| core_active | input | NUM_CORES | One bit per core, 1 = awake, 0 = power-gated |
| graded_mode | input | 1 | Policy select: 0 = threshold, 1 = graded |
| base_budget | input | BUDGET_W | Unscaled per-core power budget |
| freq_code | output | FREQ_W | Selected operating-point code |
| mult_smooth | output | 8 | Smoothed gain, unsigned Q2.6 |
| core_budget | output | BUDGET_W | Scaled per-core power budget |

## Verification
Each policy is driven with every awake count from zero to all cores. This separates the threshold code boundary from the graded one and shows that zero awake falls back to base code and unity gain. Runs of one repeated count, long enough to fill the history, show the average settling on each table entry and ramping back down. These runs tell a wrong table value apart from a wrong averaging window. A strobe held high for many cycles, and a base budget that changes between accept and publish, test the ignored-strobe and sampling-edge rules. The largest base budget at full gain tests truncation. A long pseudo-random stretch of masks, policies, bases and gaps is checked against a behavioural model on every cycle.

// File: rtl/acb_pkg.sv
package acb_pkg;

    localparam int MULT_W    = 8;
    localparam int MULT_FRAC = 6;

    // Gain values in unsigned Q2.6
    localparam logic [MULT_W-1:0] MULT_ONE = 8'd64;
    localparam logic [MULT_W-1:0] MULT_G1  = 8'd77;
    localparam logic [MULT_W-1:0] MULT_G2  = 8'd102;
    localparam logic [MULT_W-1:0] MULT_MAX = 8'd128;

    typedef logic [MULT_W-1:0] mult_t;

    typedef enum logic [1:0] {
        ST_WAIT    = 2'd0,
        ST_ACCUM   = 2'd1,
        ST_PUBLISH = 2'd2
    } acb_state_e;

endpackage

// File: rtl/acb_active_count.sv
module acb_active_count #(
    parameter int NUM_CORES = 4,
    parameter int CNT_W     = $clog2(NUM_CORES + 1)
) (
    input  logic [NUM_CORES-1:0] active_i,
    output logic [CNT_W-1:0]     count_o
);

    logic [CNT_W-1:0] partial [NUM_CORES+1];

    assign partial[0] = '0;

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_add
        assign partial[g+1] = partial[g] + {{(CNT_W-1){1'b0}}, active_i[g]};
    end

    assign count_o = partial[NUM_CORES];

endmodule

// File: rtl/acb_mult_table.sv
module acb_mult_table
    import acb_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int CNT_W     = $clog2(NUM_CORES + 1)
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic             graded_i,
    output mult_t            target_o
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_CORES);

    logic [CNT_W-1:0] gated;

    always_comb begin
        gated    = FULL - count_i;
        target_o = MULT_ONE;
        if (graded_i && (count_i != '0) && (count_i < FULL)) begin
            if (gated == CNT_W'(1)) begin
                target_o = MULT_G1;
            end else if (gated == CNT_W'(2)) begin
                target_o = MULT_G2;
            end else begin
                target_o = MULT_MAX;
            end
        end
    end

endmodule

// File: rtl/acb_avg_filter.sv
module acb_avg_filter
    import acb_pkg::*;
#(
    parameter int    AVG_LOG2  = 3,
    parameter mult_t RESET_VAL = MULT_ONE
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push_i,
    input  mult_t din_i,
    output mult_t avg_o
);

    localparam int DEPTH = 1 << AVG_LOG2;
    localparam int SUM_W = MULT_W + AVG_LOG2;

    mult_t            hist [DEPTH];
    logic [SUM_W-1:0] sum_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_hist
        if (g == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    hist[g] <= RESET_VAL;
                end else if (push_i) begin
                    hist[g] <= din_i;
                end
            end
        end else begin : g_tail
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    hist[g] <= RESET_VAL;
                end else if (push_i) begin
                    hist[g] <= hist[g-1];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= SUM_W'(RESET_VAL) << AVG_LOG2;
        end else if (push_i) begin
            sum_q <= sum_q + SUM_W'(din_i) - SUM_W'(hist[DEPTH-1]);
        end
    end

    assign avg_o = MULT_W'(sum_q >> AVG_LOG2);

endmodule

// File: rtl/acb_budget_scale.sv
module acb_budget_scale
    import acb_pkg::*;
#(
    parameter int BUDGET_W = 12
) (
    input  logic [BUDGET_W-1:0] base_i,
    input  mult_t               mult_i,
    output logic [BUDGET_W-1:0] budget_o
);

    localparam int PROD_W = BUDGET_W + MULT_W;

    assign budget_o = BUDGET_W'((PROD_W'(base_i) * PROD_W'(mult_i)) >> MULT_FRAC);

endmodule

// File: rtl/acb_boost_ctrl.sv
module acb_boost_ctrl
    import acb_pkg::*;
#(
    parameter int                NUM_CORES    = 4,
    parameter int                BUDGET_W     = 12,
    parameter int                FREQ_W       = 4,
    parameter int                BOOST_THRESH = 3,
    parameter int                AVG_LOG2     = 3,
    parameter logic [FREQ_W-1:0] FREQ_BASE    = 4'd1,
    parameter logic [FREQ_W-1:0] FREQ_BOOST   = 4'd2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_stb,
    input  logic [NUM_CORES-1:0] core_active,
    input  logic                 graded_mode,
    input  logic [BUDGET_W-1:0]  base_budget,
    output logic [FREQ_W-1:0]    freq_code,
    output logic [MULT_W-1:0]    mult_smooth,
    output logic [BUDGET_W-1:0]  core_budget
);

    localparam int               CNT_W    = $clog2(NUM_CORES + 1);
    localparam logic [CNT_W-1:0] THRESH_C = CNT_W'(BOOST_THRESH);

    acb_state_e       state_q;
    acb_state_e       state_d;
    logic             accept;
    logic [CNT_W-1:0] live_count;
    logic [CNT_W-1:0] cap_count;
    logic             cap_graded;
    logic             boost_sel;
    mult_t            target;
    mult_t            avg_val;
    logic [BUDGET_W-1:0] scaled;

    // Awake-core count of the live vector
    acb_active_count #(
        .NUM_CORES (NUM_CORES),
        .CNT_W     (CNT_W)
    ) u_count (
        .active_i (core_active),
        .count_o  (live_count)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    assign accept = (state_q == ST_WAIT) && sample_stb;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT:    if (sample_stb) state_d = ST_ACCUM;
            ST_ACCUM:   state_d = ST_PUBLISH;
            ST_PUBLISH: state_d = ST_WAIT;
            default:    state_d = ST_WAIT;
        endcase
    end

    // Snapshot of count and policy at accept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_count  <= '0;
            cap_graded <= 1'b0;
        end else if (accept) begin
            cap_count  <= live_count;
            cap_graded <= graded_mode;
        end
    end

    acb_mult_table #(
        .NUM_CORES (NUM_CORES),
        .CNT_W     (CNT_W)
    ) u_table (
        .count_i  (cap_count),
        .graded_i (cap_graded),
        .target_o (target)
    );

    acb_avg_filter #(
        .AVG_LOG2  (AVG_LOG2),
        .RESET_VAL (MULT_ONE)
    ) u_avg (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (state_q == ST_ACCUM),
        .din_i  (target),
        .avg_o  (avg_val)
    );

    acb_budget_scale #(
        .BUDGET_W (BUDGET_W)
    ) u_scale (
        .base_i   (base_budget),
        .mult_i   (avg_val),
        .budget_o (scaled)
    );

    // Frequency code selection per policy
    always_comb begin
        if (cap_count == '0) begin
            boost_sel = 1'b0;
        end else if (cap_graded) begin
            boost_sel = 1'b1;
        end else begin
            boost_sel = (cap_count <= THRESH_C);
        end
    end

    // Output registers, loaded only when publishing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            freq_code   <= FREQ_BASE;
            mult_smooth <= MULT_ONE;
            core_budget <= '0;
        end else if (state_q == ST_PUBLISH) begin
            freq_code   <= boost_sel ? FREQ_BOOST : FREQ_BASE;
            mult_smooth <= avg_val;
            core_budget <= scaled;
        end
    end

endmodule

// File: rtl/acb_boost_checker.sv
module acb_boost_checker
    import acb_pkg::*;
#(
    parameter int                BUDGET_W   = 12,
    parameter int                FREQ_W     = 4,
    parameter int                AVG_LOG2   = 3,
    parameter logic [FREQ_W-1:0] FREQ_BASE  = 4'd1,
    parameter logic [FREQ_W-1:0] FREQ_BOOST = 4'd2
) (
    input logic                clk,
    input logic                rst_n,
    input acb_state_e          state,
    input logic [FREQ_W-1:0]   freq,
    input mult_t               mult,
    input logic [BUDGET_W-1:0] budget,
    input logic [BUDGET_W-1:0] base
);

    localparam int STEP = (int'(MULT_MAX) - int'(MULT_ONE)) >> AVG_LOG2;

    // R5: the average never leaves the table span
    assert_mult_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mult >= MULT_ONE) && (mult <= MULT_MAX));

    // R2 / R3: only the two defined codes appear
    assert_freq_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (freq == FREQ_BASE) || (freq == FREQ_BOOST));

    // R6: outputs hold except after a publishing cycle
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_PUBLISH) |=> ($stable(mult) && $stable(freq) && $stable(budget)));

    // R9: bounded step per publish
    assert_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PUBLISH) |=> (((int'(mult) - int'($past(mult))) <= STEP) &&
                                   ((int'($past(mult)) - int'(mult)) <= STEP)));

    // R8: unity gain passes the base budget sampled at the publishing edge
    assert_unity_budget_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PUBLISH) |=> ((mult != MULT_ONE) || (budget == $past(base))));

endmodule

bind acb_boost_ctrl acb_boost_checker #(
    .BUDGET_W   (BUDGET_W),
    .FREQ_W     (FREQ_W),
    .AVG_LOG2   (AVG_LOG2),
    .FREQ_BASE  (FREQ_BASE),
    .FREQ_BOOST (FREQ_BOOST)
) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .state  (state_q),
    .freq   (freq_code),
    .mult   (mult_smooth),
    .budget (core_budget),
    .base   (base_budget)
);

// File: tb/acb_boost_ctrl_tb_top.sv
`timescale 1ns/1ps
module acb_boost_ctrl_tb_top;

    localparam int N    = 4;
    localparam int BW   = 12;
    localparam int FW   = 4;
    localparam int BASE = 1;
    localparam int BOOST = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          stb = 1'b0;
    logic [N-1:0]  act = '0;
    logic          grd = 1'b0;
    logic [BW-1:0] bud = '0;
    logic [FW-1:0] freq_code;
    logic [7:0]    mult_smooth;
    logic [BW-1:0] core_budget;

    always #2 clk = ~clk;

    acb_boost_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_stb  (stb),
        .core_active (act),
        .graded_mode (grd),
        .base_budget (bud),
        .freq_code   (freq_code),
        .mult_smooth (mult_smooth),
        .core_budget (core_budget)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    // Behavioural reference model
    int m_hist[$] = '{64, 64, 64, 64, 64, 64, 64, 64};
    int m_busy    = 0;
    int m_cnt     = 0;
    bit m_graded  = 0;
    int m_freq    = BASE;
    int m_mult    = 64;
    int m_budget  = 0;

    function automatic int target_of(int cnt, bit g);
        if (!g || cnt == 0 || cnt >= N) return 64;
        case (N - cnt)
            1:       return 77;
            2:       return 102;
            default: return 128;
        endcase
    endfunction

    function automatic int freq_of(int cnt, bit g);
        if (cnt == 0) return BASE;
        if (g) return BOOST;
        return (cnt <= 3) ? BOOST : BASE;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hist   = '{64, 64, 64, 64, 64, 64, 64, 64};
            m_busy   = 0;
            m_freq   = BASE;
            m_mult   = 64;
            m_budget = 0;
        end else begin
            case (m_busy)
                0: if (stb) begin
                    m_cnt    = $countones(act);
                    m_graded = grd;
                    m_busy   = 2;
                end
                2: begin
                    m_hist.push_front(target_of(m_cnt, m_graded));
                    void'(m_hist.pop_back());
                    m_busy = 1;
                end
                default: begin
                    int s;
                    s = 0;
                    foreach (m_hist[i]) s += m_hist[i];
                    m_mult   = s / 8;
                    m_freq   = freq_of(m_cnt, m_graded);
                    m_budget = ((int'(bud) * m_mult) / 64) % (1 << BW);
                    m_busy   = 0;
                end
            endcase
        end
    end

    task automatic check(string tag, int act_v, int exp_v);
        n_chk++;
        if (act_v != exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act_v, exp_v, $time);
        end
    endtask

    // Compare on every falling edge
    always @(negedge clk) begin
        if (!finished && rst_n !== 1'bx) begin
            if (!rst_n) begin
                check("R1 reset freq", int'(freq_code), BASE);
                check("R1 reset mult", int'(mult_smooth), 64);
                check("R1 reset budget", int'(core_budget), 0);
            end else begin
                check(m_graded ? "R3 freq (R6 R7)" : "R2 freq (R6 R7)", int'(freq_code), m_freq);
                check("R4 R5 R6 R7 R9 mult", int'(mult_smooth), m_mult);
                check("R8 budget", int'(core_budget), m_budget);
            end
        end
    end

    task automatic pulse(logic [N-1:0] mask, bit g, int base, int gap);
        @(negedge clk);
        stb = 1'b1; act = mask; grd = g; bud = BW'(base);
        @(negedge clk);
        stb = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic summary();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2: threshold policy over all counts
        pulse(4'hF, 0, 1000, 3);
        pulse(4'h7, 0, 1000, 3);
        pulse(4'h3, 0, 1000, 3);
        pulse(4'h1, 0, 1000, 3);
        pulse(4'h0, 0, 1000, 3);
        // R3 R4 R5: graded ramps, each long enough to settle
        for (int i = 0; i < 10; i++) pulse(4'hE, 1, 1000, 2);
        for (int i = 0; i < 10; i++) pulse(4'h5, 1, 1000, 2);
        for (int i = 0; i < 12; i++) pulse(4'h8, 1, 1000, 2);
        for (int i = 0; i < 12; i++) pulse(4'hF, 1, 1000, 2);
        for (int i = 0; i < 3; i++)  pulse(4'h0, 1, 1000, 2);
        // R7: strobe held high for many cycles
        @(negedge clk);
        stb = 1'b1; act = 4'h2; grd = 1'b1; bud = 12'd800;
        repeat (30) @(negedge clk);
        stb = 1'b0;
        repeat (4) @(negedge clk);
        // R8: truncation at the largest base with full gain
        for (int i = 0; i < 10; i++) pulse(4'h4, 1, 4095, 2);
        // R8: base changes between accept and publish
        @(negedge clk);
        stb = 1'b1; act = 4'hF; grd = 1'b0; bud = 12'd100;
        @(negedge clk);
        stb = 1'b0; bud = 12'd200;
        @(negedge clk);
        bud = 12'd300;
        repeat (4) @(negedge clk);
        // Mixed pseudo-random traffic
        for (int i = 0; i < 400; i++) begin
            pulse(N'($urandom), 1'($urandom), int'($urandom % 4096), int'($urandom % 4));
        end
        repeat (5) @(negedge clk);
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule